// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block models a synchronous single-port memory whose read and write paths have the same two-edge shape. Address and control are captured on one rising edge. A read returns its word after the next active edge. A write takes its data from the bus two active edges after its address. Because both directions have the same latency, reads and writes can alternate on every clock with no idle bus cycle. Each stored word holds 32 data bits and 4 parity bits, with one parity bit for each byte lane. Writes can update any subset of the four lanes.

An active-low clock enable freezes every register when it is high, so a cycle can be stretched without ending an access. Three chip selects qualify each load cycle. A load cycle can also start a four-beat burst. On each later step cycle, the burst moves the two low address bits in interleaved or linear order, chosen by a static strap. The bidirectional data bus is split into input, output and drive-enable signals. The drive enable is held off in the cycles where the bus carries write data or no read result.

Top module: `zbt_sram`

## Requirements
- R1: An access starts only on a load cycle (`burst_step`=0) with `csa_n`=0, `csb`=1 and `csc_n`=0. A load cycle with any other chip-select pattern accesses nothing, writes nothing and ends any active burst.
- R2: Read timing. A read captured at active edge N puts the addressed word on `{par_out,dat_out}` after active edge N+1. The word stays there until the next read result replaces it.
- R3: Write timing. A write captured at active edge N stores `{par_in,dat_in}` as sampled at active edge N+2. Reads and writes may alternate on consecutive edges with no idle cycle between them.
- R4: `lane_wr_n[i]`=0 on a write writes `dat_in[8i+7:8i]` and `par_in[i]`. Lanes with `lane_wr_n[i]`=1 keep their stored bits.
- R5: While `clk_en_n`=1, rising edges are ignored: control and address inputs have no effect, and outputs and pipeline state hold. When the clock enable returns, the pipeline resumes. Write data is then taken at the write's second active edge.
- R6: Interleaved burst (`order_il`=1). On the k-th step cycle after a load, the access address keeps the upper bits of the loaded address. Its two low bits are the loaded low bits XOR (k mod 4). The direction and lane selects come from the load cycle.
- R7: Linear burst (`order_il`=0). On the k-th step cycle, the two low address bits are (loaded low bits + k) mod 4. All other rules are as in R6.
- R8: A step cycle with no active burst does nothing. This applies after reset and after a deselecting load.
- R9: `bus_drive` is 0 while `out_en_n`=1. It is also 0 in the cycle after an active edge that did not deliver a read result. That covers the write data phase, the deselected state and the first cycle after leaving it. Otherwise `bus_drive` follows `!out_en_n` combinationally.
- R10: A read captured one active edge after a write to the same address returns the new write data merged into the stored word, lane by lane.
- R11: After synchronous reset, `bus_drive` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| csa_n | input | 1 | Chip select, active low |
| csb | input | 1 | Chip select, active high |
| csc_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | 1 steps the burst counter, 0 loads a new address |
| wr_n | input | 1 | Write enable for a load cycle, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address taken on load cycles |
| order_il | input | 1 | Static strap: 1 interleaved, 0 linear burst order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dat_in | input | 32 | Write data from the bus |
| par_in | input | 4 | Write parity from the bus, bit i for lane i |
| dat_out | output | 32 | Read data |
| par_out | output | 4 | Read parity |
| bus_drive | output | 1 | High when the block drives the bus |

## Verification
The hardest case to reach from the ports is a read that lands on the same edge that commits a write to the same address. The read has to see data that is still on the input bus, merged with the lanes that keep their stored bits. The stimulus issues a write load, follows it at once with a read of the same address, and uses partial lane selects. The bench places each write's data by counting active edges, not clock edges. This lets stall cycles fall between a write's address and its data, and between burst steps, while the expected bus timing stays exact.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int LANES   = 4;
    localparam int LANE_DW = 8;
    localparam int DATA_W  = LANES * LANE_DW;
    localparam int BCNT_W  = 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef struct packed {
        lane_t par;
        data_t dat;
    } word_t;

    typedef struct packed {
        logic  vld;
        logic  wr;
        lane_t ben;
    } cmd_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    function automatic logic [BCNT_W-1:0] burst_low(input logic [BCNT_W-1:0] start,
                                                    input logic [BCNT_W-1:0] step,
                                                    input order_e ord);
        return (ord == ORD_INTERLEAVE) ? (start ^ step) : (start + step);
    endfunction

    function automatic word_t lane_merge(input word_t old_w, input word_t new_w,
                                         input lane_t ben);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (ben[i]) begin
                r.dat[i*LANE_DW +: LANE_DW] = new_w.dat[i*LANE_DW +: LANE_DW];
                r.par[i] = new_w.par[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              sel,
    input  logic              step,
    input  logic              wr_n,
    input  lane_t             lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  order_e            ord,
    output cmd_t              s1_cmd,
    output logic [ADDR_W-1:0] s1_addr
);
    localparam int HI_W = ADDR_W - BCNT_W;

    logic              b_act;
    logic [HI_W-1:0]   b_hi;
    logic [BCNT_W-1:0] b_lo;
    logic [BCNT_W-1:0] b_cnt;
    logic [BCNT_W-1:0] cnt_nx;
    logic              b_wr;
    lane_t             b_ben;

    assign cnt_nx = b_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_act   <= 1'b0;
            b_hi    <= '0;
            b_lo    <= '0;
            b_cnt   <= '0;
            b_wr    <= 1'b0;
            b_ben   <= '0;
            s1_cmd  <= '0;
            s1_addr <= '0;
        end else if (!cke_n) begin
            if (!step) begin
                if (sel) begin
                    b_act   <= 1'b1;
                    b_hi    <= addr[ADDR_W-1:BCNT_W];
                    b_lo    <= addr[BCNT_W-1:0];
                    b_cnt   <= '0;
                    b_wr    <= ~wr_n;
                    b_ben   <= ~lane_wr_n;
                    s1_cmd  <= '{vld: 1'b1, wr: ~wr_n, ben: ~lane_wr_n};
                    s1_addr <= addr;
                end else begin
                    b_act  <= 1'b0;
                    s1_cmd <= '0;
                end
            end else if (b_act) begin
                b_cnt   <= cnt_nx;
                s1_cmd  <= '{vld: 1'b1, wr: b_wr, ben: b_ben};
                s1_addr <= {b_hi, burst_low(b_lo, cnt_nx, ord)};
            end else begin
                s1_cmd <= '0;
            end
        end
    end

    assert_desel_load_R1: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !step && !sel) |=> !s1_cmd.vld);

    assert_step_keeps_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && step && b_act) |=> (s1_addr[ADDR_W-1:BCNT_W] == $past(s1_addr[ADDR_W-1:BCNT_W])));

    assert_idle_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && step && !b_act) |=> !s1_cmd.vld);

    assert_ctrl_stall_R5: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(s1_cmd) && $stable(s1_addr)));

endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  cmd_t              s1_cmd,
    input  logic [ADDR_W-1:0] s1_addr,
    input  word_t             bus_w,
    output word_t             rd_w
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t             mem [DEPTH];
    cmd_t              s2_cmd;
    logic [ADDR_W-1:0] s2_addr;
    logic              commit;
    logic              hit;

    assign commit = s2_cmd.vld && s2_cmd.wr;
    assign hit    = commit && (s2_addr == s1_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_cmd  <= '0;
            s2_addr <= '0;
        end else if (!cke_n) begin
            s2_cmd  <= s1_cmd;
            s2_addr <= s1_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !cke_n && commit) begin
            mem[s2_addr] <= lane_merge(mem[s2_addr], bus_w, s2_cmd.ben);
        end
    end

    always_comb begin
        if (hit) begin
            rd_w = lane_merge(mem[s1_addr], bus_w, s2_cmd.ben);
        end else begin
            rd_w = mem[s1_addr];
        end
    end

    assert_data_lag_R3: assert property (@(posedge clk) disable iff (rst)
        (!cke_n) |=> (s2_cmd == $past(s1_cmd) && s2_addr == $past(s1_addr)));

    assert_store_stall_R5: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(s2_cmd) && $stable(s2_addr)));

endmodule

// File: rtl/zbt_out_stage.sv
module zbt_out_stage
    import zbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cke_n,
    input  cmd_t  s1_cmd,
    input  word_t rd_w,
    input  logic  oe_n,
    output word_t q,
    output logic  drive
);
    logic  drive_q;
    word_t q_r;
    logic  rd_now;

    assign rd_now = s1_cmd.vld && !s1_cmd.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
            q_r     <= '0;
        end else if (!cke_n) begin
            drive_q <= rd_now;
            if (rd_now) begin
                q_r <= rd_w;
            end
        end
    end

    assign q     = q_r;
    assign drive = drive_q && !oe_n;

    assert_write_phase_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s1_cmd.vld && s1_cmd.wr) |=> !drive);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !s1_cmd.vld) |=> !drive);

    assert_out_stall_R5: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(q) && $stable(drive_q)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              csa_n,
    input  logic              csb,
    input  logic              csc_n,
    input  logic              burst_step,
    input  logic              wr_n,
    input  logic [3:0]        lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_il,
    input  logic              out_en_n,
    input  logic [31:0]       dat_in,
    input  logic [3:0]        par_in,
    output logic [31:0]       dat_out,
    output logic [3:0]        par_out,
    output logic              bus_drive
);
    logic              sel;
    order_e            ord;
    word_t             bus_w;
    word_t             rd_w;
    word_t             q;
    cmd_t              s1_cmd;
    logic [ADDR_W-1:0] s1_addr;

    assign sel   = !csa_n && csb && !csc_n;
    assign ord   = order_e'(order_il);
    assign bus_w = {par_in, dat_in};

    zbt_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cke_n     (clk_en_n),
        .sel       (sel),
        .step      (burst_step),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .ord       (ord),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr)
    );

    zbt_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cke_n   (clk_en_n),
        .s1_cmd  (s1_cmd),
        .s1_addr (s1_addr),
        .bus_w   (bus_w),
        .rd_w    (rd_w)
    );

    zbt_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .cke_n  (clk_en_n),
        .s1_cmd (s1_cmd),
        .rd_w   (rd_w),
        .oe_n   (out_en_n),
        .q      (q),
        .drive  (bus_drive)
    );

    assign dat_out = q.dat;
    assign par_out = q.par;

endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          csa_n = 1'b1, csb = 1'b0, csc_n = 1'b1;
    logic          burst_step = 1'b0;
    logic          wr_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic          order_il = 1'b1;
    logic          out_en_n = 1'b0;
    logic [31:0]   dat_in = '0;
    logic [3:0]    par_in = '0;
    logic [31:0]   dat_out;
    logic [3:0]    par_out;
    logic          bus_drive;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .csa_n(csa_n), .csb(csb), .csc_n(csc_n),
        .burst_step(burst_step), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .order_il(order_il), .out_en_n(out_en_n), .dat_in(dat_in), .par_in(par_in),
        .dat_out(dat_out), .par_out(par_out), .bus_drive(bus_drive)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R2";
    bit    mon_on = 1'b0;

    typedef struct { int step; logic [35:0] w; } exp_t;
    typedef struct { bit vld; bit wr; bit [3:0] ben; int a; } mc_t;

    exp_t        exp_q[$];
    logic [35:0] refmem [int];
    logic [35:0] wd_sched [int];
    int          act_cnt = 0;
    bit          exp_drive = 1'b0;
    mc_t         p1, p2;
    bit          b_act;
    int          b_base, b_k;
    bit          b_wr;
    bit [3:0]    b_ben;
    logic [35:0] last_w = '0;

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] mrg(input logic [35:0] o, input logic [35:0] n, input bit [3:0] ben);
        logic [35:0] r;
        r = o;
        for (int i = 0; i < 4; i++) begin
            if (ben[i]) begin
                r[8*i +: 8] = n[8*i +: 8];
                r[32+i]     = n[32+i];
            end
        end
        return r;
    endfunction

    function automatic void model_clear();
        p1 = '{0, 0, 4'h0, 0};
        p2 = '{0, 0, 4'h0, 0};
        b_act = 0; b_base = 0; b_k = 0; b_wr = 0; b_ben = 0;
        exp_drive = 0;
        exp_q.delete();
        wd_sched.delete();
    endfunction

    // reference behaviour, one call per rising edge
    function automatic void model(input bit ckn, input bit stp, input bit wrn,
                                  input bit [3:0] lwn, input int a, input bit [2:0] cs);
        int lo;
        logic [63:0] r;
        if (ckn) return;
        act_cnt++;
        if (p2.vld && p2.wr) begin
            refmem[p2.a] = mrg(refmem.exists(p2.a) ? refmem[p2.a] : 36'h0, {par_in, dat_in}, p2.ben);
        end
        if (p1.vld && !p1.wr) begin
            exp_drive = 1;
            exp_q.push_back('{act_cnt, refmem.exists(p1.a) ? refmem[p1.a] : 36'h0});
        end else begin
            exp_drive = 0;
        end
        p2 = p1;
        if (!stp) begin
            if (cs == 3'b010) begin
                b_act = 1; b_base = a; b_k = 0; b_wr = !wrn; b_ben = ~lwn;
                p1 = '{1, !wrn, ~lwn, a};
            end else begin
                b_act = 0;
                p1 = '{0, 0, 4'h0, 0};
            end
        end else if (b_act) begin
            b_k = (b_k + 1) % 4;
            lo = order_il ? ((b_base & 3) ^ b_k) : (((b_base & 3) + b_k) % 4);
            p1 = '{1, b_wr, b_ben, (b_base & ~3) | lo};
        end else begin
            p1 = '{0, 0, 4'h0, 0};
        end
        if (p1.vld && p1.wr) begin
            r = {$urandom(), $urandom()};
            wd_sched[act_cnt + 2] = r[35:0];
        end
    endfunction

    task automatic apply(input bit ckn, input bit stp, input bit wrn, input bit [3:0] lwn,
                         input int a, input bit [2:0] cs);
        logic [63:0] r;
        @(negedge clk);
        #2;
        clk_en_n = ckn; burst_step = stp; wr_n = wrn; lane_wr_n = lwn; addr = a[AW-1:0];
        {csa_n, csb, csc_n} = cs;
        if (wd_sched.exists(act_cnt + 1)) begin
            {par_in, dat_in} = wd_sched[act_cnt + 1];
        end else begin
            r = {$urandom(), $urandom()};
            {par_in, dat_in} = r[35:0];
        end
        @(posedge clk);
        model(ckn, stp, wrn, lwn, a, cs);
    endtask

    task automatic ld_w(input int a, input bit [3:0] lwn); apply(0, 0, 0, lwn, a, 3'b010); endtask
    task automatic ld_r(input int a);                      apply(0, 0, 1, 4'h0, a, 3'b010); endtask
    task automatic adv();                                  apply(0, 1, 1, 4'h0, 0, 3'b110); endtask
    task automatic desel();                                apply(0, 0, 0, 4'h0, 0, 3'b110); endtask
    task automatic stall();                                apply(1, 0, 0, 4'h0, 'h7F, 3'b010); endtask

    task automatic do_reset(input bit il);
        mon_on = 0;
        @(negedge clk);
        #2;
        rst = 1; order_il = il; clk_en_n = 0; burst_step = 0; {csa_n, csb, csc_n} = 3'b110;
        out_en_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        rst = 0;
        model_clear();
        @(negedge clk);
        chk(bus_drive === 1'b0, "R11 drive after reset", {35'h0, bus_drive}, 36'h0);
        mon_on = 1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t it;
            chk(bus_drive === (exp_drive && !out_en_n), "R9 drive", {35'h0, bus_drive},
                {35'h0, exp_drive && !out_en_n});
            if (exp_q.size() > 0 && exp_q[0].step == act_cnt) begin
                it = exp_q.pop_front();
                last_w = it.w;
                chk({par_out, dat_out} === it.w, cur_req, {par_out, dat_out}, it.w);
            end else if (exp_drive) begin
                chk({par_out, dat_out} === last_w, {cur_req, " hold"}, {par_out, dat_out}, last_w);
            end
        end
    end

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b1);

        cur_req = "R8";                       // step with no burst after reset
        adv(); adv(); desel();

        cur_req = "R3";
        for (int i = 0; i < 4; i++) ld_w('h10 + i, 4'h0);
        for (int i = 0; i < 4; i++) ld_w('h40 + i, 4'h0);
        cur_req = "R2";
        for (int i = 0; i < 4; i++) ld_r('h10 + i);
        cur_req = "R3";                       // alternating, no idle cycle
        ld_w('h20, 4'h0); ld_r('h11); ld_w('h21, 4'h0); ld_r('h12); ld_r('h20); ld_r('h21);

        cur_req = "R10";                      // read directly after write, same address
        ld_w('h22, 4'h0); ld_r('h22);
        ld_w('h10, 4'b0110); ld_r('h10);

        cur_req = "R4";
        ld_w('h11, 4'b1010); desel(); desel(); ld_r('h11);
        ld_w('h13, 4'b1110); ld_w('h13, 4'b0111); desel(); ld_r('h13);

        cur_req = "R1";                       // each mismatching select pattern
        apply(0, 0, 0, 4'h0, 'h12, 3'b110);
        apply(0, 0, 0, 4'h0, 'h12, 3'b000);
        apply(0, 0, 0, 4'h0, 'h12, 3'b011);
        desel(); ld_r('h12);
        cur_req = "R8";                       // step after a deselect
        ld_r('h13); desel(); adv(); adv(); ld_r('h13);

        cur_req = "R9";
        desel(); desel(); ld_r('h10); ld_r('h11);
        out_en_n = 1; ld_r('h12); ld_r('h13); out_en_n = 0;
        ld_w('h23, 4'h0); ld_r('h20); desel();

        cur_req = "R6";
        ld_r('h41); adv(); adv(); adv(); adv();
        ld_w('h42, 4'h0); adv(); adv(); adv();
        desel();
        for (int i = 0; i < 4; i++) ld_r('h40 + i);

        cur_req = "R5";
        ld_r('h40); stall(); stall(); ld_r('h41); stall();
        ld_w('h50, 4'h0); stall(); stall(); desel(); stall(); desel(); ld_r('h50);
        ld_r('h41); adv(); stall(); adv(); stall(); desel();
        desel(); desel(); desel();
        chk(exp_q.size() == 0, "R2 results drained", exp_q.size(), 0);

        do_reset(1'b0);
        cur_req = "R7";
        for (int i = 0; i < 4; i++) ld_w('h60 + i, 4'h0);
        ld_r('h61); adv(); adv(); adv(); adv();
        ld_w('h63, 4'h0); adv(); adv();
        desel();
        for (int i = 0; i < 4; i++) ld_r('h60 + i);
        desel(); desel(); desel();
        chk(exp_q.size() == 0, "R7 results drained", exp_q.size(), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule